// File: doc/BRIEF.md
# Sequential Integer Divider with Divide-Error Trap

This block divides a double-width dividend, presented as separate high and low halves, by a single-width divisor. It produces a single-width quotient and a single-width remainder. A mode input selects unsigned or two's-complement signed operation. The block sets no arithmetic flags. It raises an error strobe instead when the divisor is zero or when the exact quotient does not fit the single-width result. When the strobe fires, the quotient and remainder outputs keep their previous values.

A caller pulses `start_i` with the operands while the unit is idle. The unit then shifts out one quotient bit per cycle using a restoring shift-subtract loop on magnitudes, and corrects the signs at the end. `done_o` marks the single cycle in which the results or the error strobe become visible. To present a negative single-width dividend in signed mode, the caller fills the high half with copies of the low half's top bit. A zero high half always denotes a non-negative dividend.

Top module: `div_trap_unit`

## Requirements
- R1: The dividend is {dvd_hi_i, dvd_lo_i}. In signed mode its sign is bit W-1 of dvd_hi_i alone. For example, with W=16, high 0x0000, low 0x8000 and divisor 0xFFFF in signed mode, the result is quotient 0x8000, remainder 0 and no error.
- R2: In unsigned mode, when dvd_hi_i < dvs_i, quo_o and rem_o equal the floor quotient and the remainder of the unsigned division.
- R3: A zero divisor raises err_o in both modes.
- R4: A quotient that does not fit raises err_o. In unsigned mode this is the case whenever dvd_hi_i >= dvs_i. In signed mode it is the case when the exact quotient lies outside [-2^(W-1), 2^(W-1)-1]. One such case is high all ones, low 0x8000, divisor all ones.
- R5: Signed division truncates toward zero. The remainder has the dividend's sign, and its magnitude is below the divisor's magnitude.
- R6: When err_o is raised, quo_o and rem_o keep the values they held before the operation.
- R7: done_o is high for exactly one cycle per accepted start. err_o is high only in that cycle, and it is the only overflow indication.
- R8: Count the clock edges from the edge that samples start_i, with that edge as the first. done_o is visible after W+2 edges for any operation that reaches the loop. It is visible after 2 edges when the divisor is zero or when the high-half magnitude check of R4 fails up front. busy_o is high from the edge after the start until done_o rises.
- R9: A start_i pulse while busy_o is high is ignored and does not alter the running operation's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division; sampled only when idle |
| signed_i | input | 1 | 1 selects two's-complement operation |
| dvd_hi_i | input | W | Upper half of dividend |
| dvd_lo_i | input | W | Lower half of dividend |
| dvs_i | input | W | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Divide-error strobe, coincident with done_o |
| quo_o | output | W | Quotient |
| rem_o | output | W | Remainder |

## Verification
A wrong iteration count or a stuck loop shows first as a completion pulse that arrives at the wrong edge, so every operation's latency is measured against W+2 or 2. A corrupted partial remainder or sign flag shows up in the first result that follows, and an independent wide-integer division catches it on every operation. A missed range check shows as a wrapped quotient with no strobe, and a missed hold shows as outputs that change on an error cycle. Both show in the same done cycle. The minimum-by-minus-one, positive 2^(W-1)-by-minus-one and largest unsigned quotient cases are run directly.

// File: rtl/div_trap_pkg.sv
package div_trap_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 16
) (
  input  logic           signed_i,
  input  logic [W-1:0]   hi_i,
  input  logic [W-1:0]   lo_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] dvd_mag_o,
  output logic [W-1:0]   dvs_mag_o,
  output logic           dvd_neg_o,
  output logic           dvs_neg_o,
  output logic           early_err_o
);
  logic [2*W-1:0] dvd;

  assign dvd       = {hi_i, lo_i};
  // sign lives in the top bit of the high half only
  assign dvd_neg_o = signed_i & dvd[2*W-1];
  assign dvs_neg_o = signed_i & dvs_i[W-1];
  assign dvd_mag_o = dvd_neg_o ? ((2*W)'(0) - dvd) : dvd;
  assign dvs_mag_o = dvs_neg_o ? (W'(0) - dvs_i) : dvs_i;
  // quotient magnitude fits W bits iff high magnitude < divisor magnitude
  assign early_err_o = (dvs_mag_o == '0) || (dvd_mag_o[2*W-1:W] >= dvs_mag_o);
endmodule

// File: rtl/div_shift_core.sv
module div_shift_core #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] dvd_mag_i,
  input  logic [W-1:0]   dvs_mag_i,
  output logic [W-1:0]   quo_o,
  output logic [W-1:0]   rem_o
);
  logic [W-1:0] rem_q, acc_q, dvs_q;
  logic [W:0]   shifted;
  logic         take;

  assign shifted = {rem_q, acc_q[W-1]};
  assign take    = shifted >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      acc_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= dvd_mag_i[2*W-1:W];
      acc_q <= dvd_mag_i[W-1:0];
      dvs_q <= dvs_mag_i;
    end else if (step_i) begin
      rem_q <= take ? (shifted[W-1:0] - dvs_q) : shifted[W-1:0];
      acc_q <= {acc_q[W-2:0], take};
    end
  end

  assign quo_o = acc_q;
  assign rem_o = rem_q;

  // R5: partial remainder stays below divisor magnitude throughout the loop
  assert_rem_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (rem_q < dvs_q));
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int W = 16
) (
  input  logic         signed_i,
  input  logic         quo_neg_i,
  input  logic         rem_neg_i,
  input  logic [W-1:0] quo_mag_i,
  input  logic [W-1:0] rem_mag_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         range_err_o
);
  localparam logic [W-1:0] MinMag = W'(1) << (W-1);

  assign quo_o = quo_neg_i ? (W'(0) - quo_mag_i) : quo_mag_i;
  assign rem_o = rem_neg_i ? (W'(0) - rem_mag_i) : rem_mag_i;
  assign range_err_o = signed_i &&
                       (quo_neg_i ? (quo_mag_i > MinMag) : quo_mag_i[W-1]);
endmodule

// File: rtl/div_trap_unit.sv
module div_trap_unit
  import div_trap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dvd_hi_i,
  input  logic [W-1:0] dvd_lo_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LastCnt = CW'(W - 1);

  div_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic           sgn_q, qneg_q, rneg_q, early_q;
  logic           done_q, err_q;
  logic [W-1:0]   quo_q, rem_q;

  logic [2*W-1:0] dvd_mag;
  logic [W-1:0]   dvs_mag, core_quo, core_rem, fix_quo, fix_rem;
  logic           dvd_neg, dvs_neg, early_err, range_err, accept, fin_err;

  assign accept = (state_q == ST_IDLE) && start_i;

  div_operand_prep #(.W(W)) u_prep (
    .signed_i   (signed_i),
    .hi_i       (dvd_hi_i),
    .lo_i       (dvd_lo_i),
    .dvs_i      (dvs_i),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .dvd_neg_o  (dvd_neg),
    .dvs_neg_o  (dvs_neg),
    .early_err_o(early_err)
  );

  div_shift_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .step_i   (state_q == ST_RUN),
    .dvd_mag_i(dvd_mag),
    .dvs_mag_i(dvs_mag),
    .quo_o    (core_quo),
    .rem_o    (core_rem)
  );

  div_sign_fix #(.W(W)) u_fix (
    .signed_i   (sgn_q),
    .quo_neg_i  (qneg_q),
    .rem_neg_i  (rneg_q),
    .quo_mag_i  (core_quo),
    .rem_mag_i  (core_rem),
    .quo_o      (fix_quo),
    .rem_o      (fix_rem),
    .range_err_o(range_err)
  );

  assign fin_err = early_q | range_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sgn_q   <= 1'b0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      early_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      quo_q   <= '0;
      rem_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sgn_q   <= signed_i;
          qneg_q  <= dvd_neg ^ dvs_neg;
          rneg_q  <= dvd_neg;
          early_q <= early_err;
          cnt_q   <= '0;
          state_q <= early_err ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LastCnt) state_q <= ST_FIN;
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          err_q   <= fin_err;
          if (!fin_err) begin
            quo_q <= fix_quo;
            rem_q <= fix_rem;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  assert_hold_on_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> ($stable(quo_o) && $stable(rem_o)));
  assert_zero_div_fast_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dvs_i == '0) |=> (state_q == ST_FIN));
  assert_idle_at_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_cnt_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (cnt_q <= LastCnt));
endmodule

// File: tb/div_trap_unit_bench.sv
module div_trap_unit_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sgn = 1'b0;
  logic [W-1:0] hi = '0, lo = '0, dv = '0;
  logic busy, done, err;
  logic [W-1:0] quo, rem;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  div_trap_unit #(.W(W)) u_div_trap_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .dvd_hi_i(hi), .dvd_lo_i(lo), .dvs_i(dv),
    .busy_o(busy), .done_o(done), .err_o(err), .quo_o(quo), .rem_o(rem)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void ref_div(input bit s, input logic [W-1:0] h, l, d,
                                  output bit e, output logic [W-1:0] q, r);
    longint a, b, qq, rr;
    if (s) begin
      a = longint'($signed({h, l}));
      b = longint'($signed(d));
    end else begin
      a = {32'd0, h, l};
      b = {48'd0, d};
    end
    q = '0; r = '0;
    if (b == 0) e = 1'b1;
    else begin
      qq = a / b;
      rr = a % b;
      e = s ? (qq < -32768 || qq > 32767) : (qq > 65535);
      q = qq[W-1:0];
      r = rr[W-1:0];
    end
  endfunction

  function automatic bit ref_early(input bit s, input logic [W-1:0] h, l, d);
    longint a, b;
    if (s) begin
      a = longint'($signed({h, l}));
      b = longint'($signed(d));
      if (a < 0) a = -a;
      if (b < 0) b = -b;
    end else begin
      a = {32'd0, h, l};
      b = {48'd0, d};
    end
    return (b == 0) || ((a >>> W) >= b);
  endfunction

  task automatic run(input bit s, input logic [W-1:0] h, l, d, input bit intrude);
    bit e_exp, early;
    logic [W-1:0] q_exp, r_exp, q_prev, r_prev;
    int cyc;
    ref_div(s, h, l, d, e_exp, q_exp, r_exp);
    early = ref_early(s, h, l, d);
    q_prev = quo; r_prev = rem;
    @(negedge clk);
    sgn = s; hi = h; lo = l; dv = d; start = 1'b1;
    @(posedge clk); cyc = 1;
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 100) begin
      chk(busy == 1'b1, "R8", "busy while running", longint'(busy), 1);
      if (intrude && cyc == 3) begin  // R9: second start while busy
        start = 1'b1; sgn = ~s; hi = ~h; lo = l ^ 16'h5a5a; dv = 16'h0000;
      end else start = 1'b0;
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cyc == (early ? 2 : W + 2), "R8", "latency", cyc, early ? 2 : W + 2);
    chk(err == e_exp, e_exp ? "R3/R4" : "R7", "err strobe", longint'(err), longint'(e_exp));
    if (e_exp) begin
      chk(quo == q_prev && rem == r_prev, "R6", "hold on error",
          {quo, rem}, {q_prev, r_prev});
    end else begin
      chk(quo == q_exp, s ? "R5" : "R2", "quotient", quo, q_exp);
      chk(rem == r_exp, s ? "R5" : "R2", "remainder", rem, r_exp);
    end
    @(posedge clk); @(negedge clk);
    chk(!done && !err, "R7", "single done pulse", {done, err}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && quo == '0 && rem == '0, "R7", "reset state",
        {busy, done, err, quo, rem}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: zero high half means positive dividend
    run(1'b1, 16'h0000, 16'h8000, 16'hffff, 1'b0);
    chk(quo == 16'h8000 && rem == 16'h0000, "R1", "positive 2^15 / -1", quo, 16'h8000);
    // R4: sign-extended minimum by -1
    run(1'b1, 16'hffff, 16'h8000, 16'hffff, 1'b0);
    // R3: zero divisor both modes
    run(1'b1, 16'h0000, 16'h0007, 16'h0000, 1'b0);
    run(1'b0, 16'h0000, 16'h0007, 16'h0000, 1'b0);
    // R2: largest unsigned quotient
    run(1'b0, 16'hfffe, 16'hffff, 16'hffff, 1'b0);
    chk(quo == 16'hffff && rem == 16'hfffe, "R2", "largest unsigned quotient", quo, 16'hffff);
    // R4: unsigned high == divisor
    run(1'b0, 16'h0005, 16'h0000, 16'h0005, 1'b0);
    // R5: truncation toward zero, remainder sign
    run(1'b1, 16'hffff, 16'hfff9, 16'h0002, 1'b0);
    chk(quo == 16'hfffd && rem == 16'hffff, "R5", "-7/2", quo, 16'hfffd);
    run(1'b1, 16'h0000, 16'h0007, 16'hfffe, 1'b0);
    // R4: signed quotient exactly -2^15 fits; +2^15 does not
    run(1'b1, 16'hffff, 16'h8000, 16'h0001, 1'b0);
    run(1'b1, 16'h0000, 16'h8000, 16'h0001, 1'b0);
    // R9: start during busy ignored
    run(1'b0, 16'h0012, 16'h3456, 16'h0100, 1'b1);
    run(1'b1, 16'hffff, 16'hc000, 16'h0003, 1'b1);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      bit s;
      logic [W-1:0] h, l, d;
      s = $urandom_range(0, 1);
      l = $urandom;
      d = $urandom;
      case ($urandom_range(0, 3))
        0: h = $urandom;
        1: h = s ? {W{l[W-1]}} : '0;
        2: h = d >> $urandom_range(1, 8);
        default: h = s ? (l[W-1] ? 16'hffff : 16'h0000) ^ 16'(($urandom_range(0, 3))) : 16'($urandom_range(0, 255));
      endcase
      if ($urandom_range(0, 15) == 0) d = '0;
      if ($urandom_range(0, 15) == 0) d = 16'hffff;
      run(s, h, l, d, ($urandom_range(0, 19) == 0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule